// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target with Write Locking

This block is a two-wire serial bus target that sits in front of a 256-byte storage array. It oversamples the SCL and SDA lines with the system clock, recognises START and STOP framing, and checks the first byte of each transaction against a device-kind code and three strap pins. Bytes that follow either set the word pointer and carry write data, or are answered with read data taken from the pointer. The pointer advances after every byte and wraps from the top address to zero. SDA is open-drain. The block only ever pulls the line low, through `sda_drive`, and the surrounding logic forms the wired-AND.

Write data does not reach the array as it arrives. Each transaction's bytes are gathered in a small buffer, and they are written all at once in the cycle after a STOP. A START that cuts a write short throws the buffer away. A second device kind addresses a one-shot lock register, and writing it locks the lower half of the array for good. A level input, `prot_pin`, blocks writes to every location while it is high. Both protections are applied per byte at commit time. Blocked bytes are still acknowledged on the bus, so the master sees no difference.

The only data path at the block's edge is the two-wire bus itself. This block never holds the clock low, so it applies no back-pressure. Inside, the byte path from the bus engine into the write buffer is a valid-only push. A byte that finds the buffer full is dropped, not stalled.

Top module: `eep_i2c_wp`

## Requirements
- R1: After reset, and until a START (SDA falling while SCL is high) is seen, the block never drives SDA, whatever SCL and SDA do.
- R2: A STOP (SDA rising while SCL is high) ends any transaction and releases SDA. Bus bits clocked after it get no response until the next START.
- R3: Buffered write data changes the array only when a STOP ends the write. A write ended by a repeated START leaves every location unchanged.
- R4: The first byte after START is split into bits [7:4] = device kind, bits [3:1] = select, bit [0] = direction (0 write, 1 read). Kind 4'b1010 addresses the array and kind 4'b0110 addresses the lock register. Any other kind is not acknowledged.
- R5: When the select bits differ from `strap_sel`, the first byte is not acknowledged and the rest of the transaction is ignored.
- R6: The block pulls SDA low during the ninth clock of every byte it receives while addressed, including data bytes to protected locations. During reads it releases SDA on the ninth clock. A master NACK there ends the read, and SDA stays released.
- R7: In a write, the byte after the device byte loads the word pointer. Reads return the byte at the pointer. The pointer increases by one after every data byte, written or read, and wraps from 8'hFF to 8'h00. A write of only the pointer followed by a repeated START and a read gives a random read. A read with no pointer byte continues from the current pointer.
- R8: A write-direction device byte of kind 4'b0110, ended by a STOP, sets a permanent lock flag that never clears until reset. Once the flag is set, kind 4'b0110 is not acknowledged in either direction. A read-direction kind 4'b0110 is never acknowledged.
- R9: While the lock flag is set, bytes aimed at addresses 8'h00 to 8'h7F are discarded at commit. Bytes aimed at 8'h80 to 8'hFF are still written, provided `prot_pin` is low.
- R10: While `prot_pin` is high at commit, no location changes. While it is low, only the lock flag restricts writes.
- R11: Each write transaction keeps at most BUF_DEPTH (16) data bytes. Later bytes are acknowledged and advance the pointer, but they are discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad (wired-AND value) |
| strap_sel | input | 3 | Select strap that the device byte must match |
| prot_pin | input | 1 | High blocks writes to the whole array |
| sda_drive | output | 1 | High pulls SDA low (open-drain enable) |

## Verification
The main function is tried with directed sequences and with seeded random write-then-read pairs. Each random pair picks its own address, length and data, and the protect pin is raised at random for some pairs. Random pairs whose address runs past 8'hFF separate correct pointer wrapping from a stuck or saturating pointer. Random writes that end in a repeated START separate commit-on-STOP from writing each byte as it arrives. A 20-byte burst tells buffer truncation apart from pointer truncation. Writes that straddle 8'h7F/8'h80 after locking show that the lock covers the lower half only. Bits clocked with no START, and again after a STOP, show whether the block answers traffic that was never addressed to it.

// File: rtl/eep_pkg.sv
package eep_pkg;

  localparam logic [3:0] KIND_MEM  = 4'b1010;
  localparam logic [3:0] KIND_LOCK = 4'b0110;

  typedef enum logic [2:0] {
    LS_IDLE,
    LS_DEV,
    LS_WORD,
    LS_DATA,
    LS_LOCK,
    LS_READ,
    LS_SKIP
  } link_state_e;

  typedef struct packed {
    logic [3:0] kind;
    logic [2:0] sel;
    logic       rd;
  } dev_byte_t;

endpackage

// File: rtl/eep_bus_sync.sv
module eep_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  input  logic pin_in,
  output logic scl_rise,
  output logic scl_fall,
  output logic sda_s,
  output logic pin_s,
  output logic start_evt,
  output logic stop_evt
);
  localparam int         LINES = 3;
  localparam logic [2:0] IDLE_V = 3'b011;   // pin low, sda high, scl high

  logic [STAGES-1:0][LINES-1:0] stg;
  logic [LINES-1:0] raw, last;
  logic scl_d, sda_d;

  assign raw  = {pin_in, sda_in, scl_in};
  assign last = stg[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg <= {STAGES{IDLE_V}};
    end else begin
      stg[0] <= raw;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= last[0];
      sda_d <= last[1];
    end
  end

  assign sda_s     = last[1];
  assign pin_s     = last[2];
  assign scl_rise  = last[0] & ~scl_d;
  assign scl_fall  = ~last[0] & scl_d;
  assign start_evt = last[0] & scl_d & sda_d & ~last[1];
  assign stop_evt  = last[0] & scl_d & ~sda_d & last[1];

endmodule

// File: rtl/eep_link.sv
module eep_link
  import eep_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_s,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic [2:0]        strap_sel,
  input  logic              locked,
  input  logic [7:0]        rd_byte,
  output logic              drive,
  output link_state_e       state,
  output logic [ADDR_W-1:0] ptr,
  output logic              push_valid,
  output logic [ADDR_W-1:0] push_addr,
  output logic [7:0]        push_data,
  output logic              commit,
  output logic              buf_clear,
  output logic              lock_set
);
  localparam logic [3:0] LAST_BIT = 4'd8;

  logic [3:0]  bit_cnt;
  logic        ack_ph, mack_ph, lock_pend;
  logic [7:0]  shreg, tx;
  dev_byte_t   hdr;
  logic        dec_ack, dec_lock;
  link_state_e dec_next;

  assign hdr = dev_byte_t'(shreg);

  // decision taken at the fall that follows the eighth received bit
  always_comb begin
    dec_ack  = 1'b0;
    dec_lock = 1'b0;
    dec_next = LS_SKIP;
    case (state)
      LS_DEV: begin
        if (hdr.sel == strap_sel) begin
          if (hdr.kind == KIND_MEM) begin
            dec_ack  = 1'b1;
            dec_next = hdr.rd ? LS_READ : LS_WORD;
          end else if (hdr.kind == KIND_LOCK && !hdr.rd && !locked) begin
            dec_ack  = 1'b1;
            dec_lock = 1'b1;
            dec_next = LS_LOCK;
          end
        end
      end
      LS_WORD: begin dec_ack = 1'b1; dec_next = LS_DATA; end
      LS_DATA: begin dec_ack = 1'b1; dec_next = LS_DATA; end
      LS_LOCK: begin dec_ack = 1'b1; dec_next = LS_LOCK; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= LS_IDLE;
      bit_cnt    <= '0;
      ack_ph     <= 1'b0;
      mack_ph    <= 1'b0;
      lock_pend  <= 1'b0;
      shreg      <= '0;
      tx         <= '0;
      ptr        <= '0;
      drive      <= 1'b0;
      push_valid <= 1'b0;
      push_addr  <= '0;
      push_data  <= '0;
      commit     <= 1'b0;
      buf_clear  <= 1'b0;
      lock_set   <= 1'b0;
    end else begin
      push_valid <= 1'b0;
      commit     <= 1'b0;
      buf_clear  <= 1'b0;
      lock_set   <= 1'b0;
      if (start_evt) begin
        state     <= LS_DEV;
        bit_cnt   <= '0;
        ack_ph    <= 1'b0;
        mack_ph   <= 1'b0;
        drive     <= 1'b0;
        buf_clear <= 1'b1;
        lock_pend <= 1'b0;
      end else if (stop_evt) begin
        state     <= LS_IDLE;
        ack_ph    <= 1'b0;
        mack_ph   <= 1'b0;
        drive     <= 1'b0;
        commit    <= 1'b1;
        lock_set  <= lock_pend;
        lock_pend <= 1'b0;
      end else if (ack_ph) begin
        if (scl_fall) begin
          ack_ph  <= 1'b0;
          bit_cnt <= '0;
          if (state == LS_READ) begin
            drive <= ~rd_byte[7];
            tx    <= {rd_byte[6:0], 1'b0};
            ptr   <= ptr + 1'b1;
          end else begin
            drive <= 1'b0;
          end
        end
      end else if (state == LS_READ) begin
        if (mack_ph) begin
          if (scl_rise && sda_s) begin
            state   <= LS_SKIP;
            mack_ph <= 1'b0;
          end else if (scl_fall) begin
            mack_ph <= 1'b0;
            bit_cnt <= '0;
            drive   <= ~rd_byte[7];
            tx      <= {rd_byte[6:0], 1'b0};
            ptr     <= ptr + 1'b1;
          end
        end else begin
          if (scl_rise) bit_cnt <= bit_cnt + 1'b1;
          if (scl_fall) begin
            if (bit_cnt == LAST_BIT) begin
              drive   <= 1'b0;
              mack_ph <= 1'b1;
            end else begin
              drive <= ~tx[7];
              tx    <= {tx[6:0], 1'b0};
            end
          end
        end
      end else if (state inside {LS_DEV, LS_WORD, LS_DATA, LS_LOCK}) begin
        if (scl_rise) begin
          shreg   <= {shreg[6:0], sda_s};
          bit_cnt <= bit_cnt + 1'b1;
        end
        if (scl_fall && bit_cnt == LAST_BIT) begin
          bit_cnt <= '0;
          state   <= dec_next;
          ack_ph  <= dec_ack;
          drive   <= dec_ack;
          if (dec_lock) lock_pend <= 1'b1;
          if (state == LS_WORD) ptr <= shreg[ADDR_W-1:0];
          if (state == LS_DATA) begin
            push_valid <= 1'b1;
            push_addr  <= ptr;
            push_data  <= shreg;
            ptr        <= ptr + 1'b1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/eep_store.sv
module eep_store #(
  parameter int ADDR_W    = 8,
  parameter int BUF_DEPTH = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          push_valid,
  input  logic [ADDR_W-1:0]             push_addr,
  input  logic [7:0]                    push_data,
  input  logic                          buf_clear,
  input  logic                          commit,
  input  logic                          lock_set,
  input  logic                          pin_s,
  output logic                          locked,
  output logic [(1<<ADDR_W)-1:0][7:0]   mem_q
);
  localparam int CNT_W = $clog2(BUF_DEPTH + 1);
  localparam int IDX_W = (BUF_DEPTH > 1) ? $clog2(BUF_DEPTH) : 1;

  logic [BUF_DEPTH-1:0][ADDR_W-1:0] b_addr;
  logic [BUF_DEPTH-1:0][7:0]        b_data;
  logic [CNT_W-1:0]                 cnt;
  logic [IDX_W-1:0]                 widx;
  logic                             has_room;
  logic [BUF_DEPTH-1:0]             keep;

  assign widx     = cnt[IDX_W-1:0];
  assign has_room = cnt < CNT_W'(BUF_DEPTH);

  // per-entry write permission, judged against the state at commit time
  for (genvar g = 0; g < BUF_DEPTH; g++) begin : g_keep
    assign keep[g] = (CNT_W'(g) < cnt) && !pin_s
                   && !(locked && !b_addr[g][ADDR_W-1]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      b_addr <= '0;
      b_data <= '0;
    end else if (buf_clear || commit) begin
      cnt <= '0;
    end else if (push_valid && has_room) begin
      b_addr[widx] <= push_addr;
      b_data[widx] <= push_data;
      cnt          <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_q <= '0;
    end else if (commit) begin
      for (int i = 0; i < BUF_DEPTH; i++)
        if (keep[i]) mem_q[b_addr[i]] <= b_data[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        locked <= 1'b0;
    else if (lock_set) locked <= 1'b1;
  end

endmodule

// File: rtl/eep_i2c_wp.sv
module eep_i2c_wp
  import eep_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int BUF_DEPTH   = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  input  logic [2:0] strap_sel,
  input  logic       prot_pin,
  output logic       sda_drive
);
  localparam int DEPTH = 1 << ADDR_W;

  logic scl_rise, scl_fall, sda_s, pin_s, start_evt, stop_evt;
  logic push_valid, commit, buf_clear, lock_set, locked;
  logic [ADDR_W-1:0] ptr, push_addr;
  logic [7:0] push_data, rd_byte;
  logic [DEPTH-1:0][7:0] mem_q;
  link_state_e link_state;

  eep_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_in   (scl_in),
    .sda_in   (sda_in),
    .pin_in   (prot_pin),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .sda_s    (sda_s),
    .pin_s    (pin_s),
    .start_evt(start_evt),
    .stop_evt (stop_evt)
  );

  eep_link #(.ADDR_W(ADDR_W)) u_link (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .sda_s     (sda_s),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .strap_sel (strap_sel),
    .locked    (locked),
    .rd_byte   (rd_byte),
    .drive     (sda_drive),
    .state     (link_state),
    .ptr       (ptr),
    .push_valid(push_valid),
    .push_addr (push_addr),
    .push_data (push_data),
    .commit    (commit),
    .buf_clear (buf_clear),
    .lock_set  (lock_set)
  );

  eep_store #(.ADDR_W(ADDR_W), .BUF_DEPTH(BUF_DEPTH)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_valid(push_valid),
    .push_addr (push_addr),
    .push_data (push_data),
    .buf_clear (buf_clear),
    .commit    (commit),
    .lock_set  (lock_set),
    .pin_s     (pin_s),
    .locked    (locked),
    .mem_q     (mem_q)
  );

  assign rd_byte = mem_q[ptr];

endmodule

// File: rtl/eep_i2c_wp_chk.sv
module eep_i2c_wp_chk
  import eep_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        sda_drive,
  input link_state_e                 state,
  input logic                        stop_evt,
  input logic                        commit,
  input logic                        locked,
  input logic                        pin_s,
  input logic [(1<<ADDR_W)-1:0][7:0] mem_q
);
  localparam int HALF = (1 << ADDR_W) / 2;

  AST_QUIET_UNADDRESSED: assert property (@(posedge clk) disable iff (!rst_n)
    (state == LS_IDLE || state == LS_SKIP) |-> !sda_drive);                  // R1

  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> (state == LS_IDLE && !sda_drive));                          // R2

  AST_WRITE_ONLY_AT_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(mem_q));                                             // R3

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);                                                      // R8

  AST_LOWER_HALF_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && locked) |=> $stable(mem_q[HALF-1:0]));                        // R9

  AST_PIN_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && pin_s) |=> $stable(mem_q));                                   // R10

endmodule

bind eep_i2c_wp eep_i2c_wp_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sda_drive(sda_drive),
  .state    (link_state),
  .stop_evt (stop_evt),
  .commit   (commit),
  .locked   (locked),
  .pin_s    (pin_s),
  .mem_q    (mem_q)
);

// File: tb/test_eep_i2c_wp.sv
module test_eep_i2c_wp;
  localparam int Q    = 5;
  localparam int BUFD = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, pin = 1'b0;
  logic [2:0] strap = 3'b101;
  logic sda_drive;
  wire  sda_bus = sda_m & ~sda_drive;

  always #10 clk = ~clk;

  eep_i2c_wp i_eep_i2c_wp (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_in   (scl_m),
    .sda_in   (sda_bus),
    .strap_sel(strap),
    .prot_pin (pin),
    .sda_drive(sda_drive)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;
  bit [7:0] ref_mem [256];
  bit ref_lock = 1'b0;
  bit [7:0] ref_ptr = 8'h00;
  bit [7:0] wdata [32];
  bit mon_en = 1'b0, seen_drive = 1'b0;

  always @(negedge clk) if (mon_en && sda_drive) seen_drive = 1'b1;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic bit may_write(input int a);
    return !pin && !(ref_lock && a < 128);
  endfunction

  task automatic wait_q(); repeat (Q) @(negedge clk); endtask

  task automatic m_start();
    sda_m = 1'b1; wait_q(); scl_m = 1'b1; wait_q();
    sda_m = 1'b0; wait_q(); scl_m = 1'b0; wait_q();
  endtask

  task automatic m_stop();
    sda_m = 1'b0; wait_q(); scl_m = 1'b1; wait_q();
    sda_m = 1'b1; wait_q(); wait_q();
  endtask

  task automatic m_bit(input logic b, output logic r);
    sda_m = b; wait_q(); scl_m = 1'b1; wait_q();
    r = sda_bus; wait_q(); scl_m = 1'b0; wait_q();
  endtask

  task automatic m_wbyte(input logic [7:0] b, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) m_bit(b[i], r);
    m_bit(1'b1, r);
    ack = !r;
  endtask

  task automatic m_rbyte(input logic nack, output logic [7:0] d);
    logic r;
    for (int i = 7; i >= 0; i--) begin m_bit(1'b1, r); d = {d[6:0], r}; end
    m_bit(nack, r);
  endtask

  // bits clocked with no START in front of them
  task automatic stray_bits(input logic [7:0] b);
    logic r;
    seen_drive = 1'b0; mon_en = 1'b1;
    scl_m = 1'b0; wait_q();
    for (int i = 7; i >= 0; i--) m_bit(b[i], r);
    m_bit(1'b1, r);
    sda_m = 1'b1; wait_q(); scl_m = 1'b1; wait_q();
    mon_en = 1'b0;
  endtask

  task automatic do_write(input logic [7:0] addr, input int n, input bit fin, input string req);
    logic ack;
    m_start();
    m_wbyte({4'b1010, strap, 1'b0}, ack); chk({req, " R6 device ACK"}, ack, 1);
    m_wbyte(addr, ack);                   chk({req, " R6 word ACK"}, ack, 1);
    for (int k = 0; k < n; k++) begin
      m_wbyte(wdata[k], ack);             chk({req, " R6 data ACK"}, ack, 1);
    end
    ref_ptr = 8'(addr + n);
    if (fin) begin
      m_stop();
      for (int k = 0; k < n && k < BUFD; k++)
        if (may_write(int'(8'(addr + k)))) ref_mem[8'(addr + k)] = wdata[k];
    end
  endtask

  task automatic do_read(input logic [7:0] addr, input int n, input string req);
    logic ack; logic [7:0] d;
    m_start();
    m_wbyte({4'b1010, strap, 1'b0}, ack); chk({req, " R6 device ACK"}, ack, 1);
    m_wbyte(addr, ack);                   chk({req, " R7 word ACK"}, ack, 1);
    m_start();
    m_wbyte({4'b1010, strap, 1'b1}, ack); chk({req, " R6 read ACK"}, ack, 1);
    for (int k = 0; k < n; k++) begin
      m_rbyte(k == n - 1, d);
      chk(req, d, ref_mem[8'(addr + k)]);
    end
    chk("R6 released after NACK", sda_drive, 0);
    m_stop();
    ref_ptr = 8'(addr + n);
  endtask

  task automatic cur_read(input string req);
    logic ack; logic [7:0] d;
    m_start();
    m_wbyte({4'b1010, strap, 1'b1}, ack); chk({req, " ACK"}, ack, 1);
    m_rbyte(1'b1, d);
    chk(req, d, ref_mem[ref_ptr]);
    m_stop();
    ref_ptr = ref_ptr + 8'd1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] a;
    int n;
    bit fin;
    void'($urandom(32'h5eed_0042));
    repeat (5) @(negedge clk);
    chk("R1 reset drive", sda_drive, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1: a matching device byte without START gets no answer
    stray_bits({4'b1010, strap, 1'b0});
    chk("R1 no START no drive", seen_drive, 0);

    // R5: select mismatch
    m_start(); m_wbyte({4'b1010, 3'b010, 1'b0}, ack); chk("R5 mismatch NACK", ack, 0); m_stop();
    // R4: unknown kind
    m_start(); m_wbyte({4'b1100, strap, 1'b0}, ack); chk("R4 unknown kind NACK", ack, 0); m_stop();

    // R3/R7: plain write and random read
    for (int k = 0; k < 4; k++) wdata[k] = 8'h30 + 8'(k * 7);
    do_write(8'h10, 4, 1, "R3 basic");
    do_read(8'h10, 4, "R3 readback");

    // R3: write cut short by repeated START
    wdata[0] = 8'h55; wdata[1] = 8'hAA;
    do_write(8'h10, 2, 0, "R3 aborted");
    do_read(8'h10, 2, "R3 unchanged after abort");

    // R7: wrap at the top
    wdata[0] = 8'hE1; wdata[1] = 8'hE2; wdata[2] = 8'hE3;
    do_write(8'hFE, 3, 1, "R7 wrap");
    do_read(8'hFE, 3, "R7 wrap read");
    cur_read("R7 current address");

    // R2: bits after a STOP are ignored
    stray_bits({4'b1010, strap, 1'b1});
    chk("R2 no drive after STOP", seen_drive, 0);

    // R11: buffer depth
    for (int k = 0; k < 20; k++) wdata[k] = 8'h80 + 8'(k);
    do_write(8'h40, 20, 1, "R11 long");
    cur_read("R11 pointer advanced past dropped bytes");
    do_read(8'h40, 20, "R11 truncated readback");

    // R10: pin blocks everything
    pin = 1'b1; repeat (10) @(negedge clk);
    wdata[0] = 8'h0F; wdata[1] = 8'hF0;
    do_write(8'h11, 1, 1, "R10 pin low half");
    do_write(8'hC0, 2, 1, "R10 pin high half");
    pin = 1'b0; repeat (10) @(negedge clk);
    do_read(8'h11, 1, "R10 low half kept");
    do_read(8'hC0, 2, "R10 high half kept");

    // seeded random pairs
    for (int it = 0; it < 20; it++) begin
      pin = ($urandom % 4) == 0;
      repeat (10) @(negedge clk);
      a   = 8'($urandom);
      n   = 1 + int'($urandom % 4);
      fin = ($urandom % 5) != 0;
      for (int k = 0; k < n; k++) wdata[k] = 8'($urandom);
      do_write(a, n, fin, fin ? "R10 random write" : "R3 random abort");
      do_read(a, n, "R7 random read");
    end
    pin = 1'b0; repeat (10) @(negedge clk);

    // R8: read direction of the lock kind is refused
    m_start(); m_wbyte({4'b0110, strap, 1'b1}, ack); chk("R8 lock read NACK", ack, 0); m_stop();
    // R8: lock command aborted by START does not lock
    m_start(); m_wbyte({4'b0110, strap, 1'b0}, ack); chk("R8 lock ACK", ack, 1);
    wdata[0] = 8'h21;
    do_write(8'h05, 1, 1, "R8 not locked after abort");
    do_read(8'h05, 1, "R8 low half still writable");
    // R8: real lock
    m_start(); m_wbyte({4'b0110, strap, 1'b0}, ack); chk("R4 lock kind ACK", ack, 1); m_stop();
    ref_lock = 1'b1;
    m_start(); m_wbyte({4'b0110, strap, 1'b0}, ack); chk("R8 second lock NACK", ack, 0); m_stop();

    // R9: straddle the halves
    wdata[0] = 8'h77; wdata[1] = 8'h88;
    do_write(8'h7F, 2, 1, "R9 straddle");
    do_read(8'h7F, 2, "R9 straddle readback");
    wdata[0] = 8'h99;
    do_write(8'h00, 1, 1, "R9 address zero");
    do_read(8'h00, 1, "R9 address zero kept");

    // R10 with lock: pin high also blocks upper half
    pin = 1'b1; repeat (10) @(negedge clk);
    wdata[0] = 8'h3C;
    do_write(8'hA0, 1, 1, "R10 locked and pin");
    pin = 1'b0; repeat (10) @(negedge clk);
    do_read(8'hA0, 1, "R10 upper half kept");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule